// File: doc/BRIEF.md
# PWM Channel Bank Register File

This block is the software-visible configuration store for a bank of pulse-width modulation channels. It holds a shared enable register with one bit per channel, and a duty register and a period register for each channel. It sends each field as a parallel output to the waveform generators that sit beside it. Software reaches it over a plain 32-bit register bus. The bus has one write strobe per access. Reads are combinational from the presented address.

Every register can be reached at four addresses. The base address replaces the whole word. The three alias addresses above it set, clear or toggle only the bits written as one. Several agents can therefore change single bits without a read-modify-write race. Writing any alias of a channel's period register raises that channel's commit strobe for one clock. The downstream generator uses this strobe to load the new settings at its next period boundary. The channel count is a parameter of up to eight. Addresses of channels that are not built behave as empty space.

Top module: `pwm_bank_regs`

## Requirements
- R1: The enable register sits at byte offset 0x000. Bit n drives `ch_enable[n]`. Bits at or above NUM_CH cannot be written and read as zero.
- R2: Address bits 3:2 select the operation on the addressed register. The value 0 replaces the register with the write data, 1 ORs the data in, 2 clears the bits that are one in the data, and 3 inverts the bits that are one in the data. Address bits 1:0 are ignored.
- R3: A read at any of the four alias offsets of a register returns that register's current value, in the same cycle as the address is presented, and the read changes nothing.
- R4: The duty register of channel n sits at 0x10 + n*0x20. Its bits 31:16 hold the duty threshold, which drives `ch_duty[16n +: 16]`. All other bits of this register read as zero.
- R5: The period register of channel n sits at 0x20 + n*0x20. Bits 15:0 hold the period count, 17:16 the active output level, 19:18 the idle output level, and 22:20 the prescaler select. Bits 31:23 read as zero. Each field drives its own output from the clock after the write.
- R6: A write to any alias of channel n's period register makes `ch_commit[n]` high for exactly the one clock after the write. No other commit bit is high in that clock.
- R7: Addresses of channels at or above NUM_CH, and any address above the last built period register, read as zero. Writes to them change no output and raise no commit.
- R8: Reset, which is synchronous and active low, clears every register and the commit strobes, so all channels start disabled with all fields at zero.
- R9: A write to a duty register or to the enable register never raises a commit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_enable | output | NUM_CH | Per-channel enable |
| ch_duty | output | 16*NUM_CH | Per-channel duty threshold |
| ch_period | output | 16*NUM_CH | Per-channel period count |
| ch_act_lvl | output | 2*NUM_CH | Per-channel active output level code |
| ch_idle_lvl | output | 2*NUM_CH | Per-channel idle output level code |
| ch_presc | output | 3*NUM_CH | Per-channel prescaler select |
| ch_commit | output | NUM_CH | One-clock strobe after a period register write |

## Verification
The bench goes after the alias arithmetic on the enable register and on partially reserved registers. A design that masked reserved bits too late, or not at all, would show stray ones on read-back after a set or toggle of all bits. It writes through addresses with bits 1:0 set and through the channel slots above NUM_CH. A decoder that used the full address, or wrapped the channel index, would corrupt a built channel or read back garbage. It watches the commit strobe across duty, enable and period writes. A strobe tied to the wrong register, held for more than one clock, or sent to a neighbouring channel shows up at once against the bench's model.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int MAX_CH = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  // Implemented bits of each register kind
  localparam logic [31:0] DUTY_MASK   = 32'hFFFF_0000;
  localparam logic [31:0] PERIOD_MASK = 32'h007F_FFFF;

  // Resulting register value for one alias operation
  function automatic logic [31:0] apply_alias(input alias_op_e op,
                                              input logic [31:0] cur,
                                              input logic [31:0] wd);
    logic [31:0] r;
    unique case (op)
      OP_WRITE: r = wd;
      OP_SET:   r = cur | wd;
      OP_CLR:   r = cur & ~wd;
      default:  r = cur ^ wd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_reg_decode.sv
module pwm_reg_decode
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W = ADDR_W - 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_duty,
  output logic              hit_per,
  output logic [CH_W-1:0]   chan,
  output alias_op_e         op
);
  logic [IDX_W-1:0] slot;
  logic             odd_half;

  assign slot     = addr[ADDR_W-1:5];
  assign odd_half = addr[4];
  assign op       = alias_op_e'(addr[3:2]);

  always_comb begin
    hit_ctrl = (addr[ADDR_W-1:4] == '0);
    hit_duty = odd_half && (slot < IDX_W'(NUM_CH));
    hit_per  = !odd_half && (slot != '0) && (slot <= IDX_W'(NUM_CH));
    if (odd_half) chan = CH_W'(slot);
    else          chan = CH_W'(slot - IDX_W'(1));
  end

endmodule

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  alias_op_e         op,
  input  logic [31:0]       wdata,
  output logic [NUM_CH-1:0] en_q
);
  logic [31:0] next_word;

  assign next_word = apply_alias(op, 32'(en_q), wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= next_word[NUM_CH-1:0];
  end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_duty,
  input  logic        wr_per,
  input  alias_op_e   op,
  input  logic [31:0] wdata,
  output logic [31:0] duty_q,
  output logic [31:0] per_q,
  output logic        commit_q
);
  logic [31:0] duty_next, per_next;

  assign duty_next = apply_alias(op, duty_q, wdata) & DUTY_MASK;
  assign per_next  = apply_alias(op, per_q,  wdata) & PERIOD_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q   <= '0;
      per_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      if (wr_duty) duty_q <= duty_next;
      if (wr_per)  per_q  <= per_next;
      commit_q <= wr_per;
    end
  end

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_CH-1:0]     ch_enable,
  output logic [16*NUM_CH-1:0]  ch_duty,
  output logic [16*NUM_CH-1:0]  ch_period,
  output logic [2*NUM_CH-1:0]   ch_act_lvl,
  output logic [2*NUM_CH-1:0]   ch_idle_lvl,
  output logic [3*NUM_CH-1:0]   ch_presc,
  output logic [NUM_CH-1:0]     ch_commit
);
  // Decoded access, brought out as named wires
  logic      hit_ctrl, hit_duty, hit_per;
  logic [CH_W-1:0] hit_chan;
  alias_op_e hit_op;
  logic      wr_ctrl;

  logic [31:0] duty_word [NUM_CH];
  logic [31:0] per_word  [NUM_CH];

  pwm_reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr     (bus_addr),
    .hit_ctrl (hit_ctrl),
    .hit_duty (hit_duty),
    .hit_per  (hit_per),
    .chan     (hit_chan),
    .op       (hit_op)
  );

  assign wr_ctrl = bus_wr && hit_ctrl;

  pwm_ctrl_reg #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_ctrl),
    .op    (hit_op),
    .wdata (bus_wdata),
    .en_q  (ch_enable)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (hit_chan == CH_W'(g));

    pwm_chan_regs regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_duty  (bus_wr && hit_duty && sel),
      .wr_per   (bus_wr && hit_per && sel),
      .op       (hit_op),
      .wdata    (bus_wdata),
      .duty_q   (duty_word[g]),
      .per_q    (per_word[g]),
      .commit_q (ch_commit[g])
    );

    assign ch_duty[16*g +: 16]    = duty_word[g][31:16];
    assign ch_period[16*g +: 16]  = per_word[g][15:0];
    assign ch_act_lvl[2*g +: 2]   = per_word[g][17:16];
    assign ch_idle_lvl[2*g +: 2]  = per_word[g][19:18];
    assign ch_presc[3*g +: 3]     = per_word[g][22:20];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = 32'(ch_enable);
    else if (hit_duty) bus_rdata = duty_word[hit_chan];
    else if (hit_per)  bus_rdata = per_word[hit_chan];
  end

endmodule

// File: rtl/pwm_bank_regs_chk.sv
module pwm_bank_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CH-1:0]    ch_enable,
  input logic [16*NUM_CH-1:0] ch_duty,
  input logic [16*NUM_CH-1:0] ch_period,
  input logic [NUM_CH-1:0]    ch_commit
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(16);

  function automatic logic is_base(input logic [ADDR_W-1:0] a, input int base);
    return (a & ~(SPAN - ADDR_W'(1))) == ADDR_W'(base);
  endfunction

  function automatic logic mapped(input logic [ADDR_W-1:0] a);
    logic m;
    m = is_base(a, 0);
    for (int n = 0; n < NUM_CH; n++)
      m = m | is_base(a, 16 + 32*n) | is_base(a, 32 + 32*n);
    return m;
  endfunction

  // R7: empty space reads as zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped(bus_addr) |-> bus_rdata == 32'd0);

  // R6: at most one channel commits per clock
  assert_commit_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_commit));

  // R1: enables move only after a write to the enable register
  assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && is_base(bus_addr, 0)) |-> $stable(ch_enable));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6 / R9: a commit follows a period write of this channel only
    assert_commit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_commit[i] |-> $past(bus_wr && is_base(bus_addr, 32 + 32*i)));

    // R6: every period write of this channel is followed by its commit
    assert_commit_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_base(bus_addr, 32 + 32*i)) |=> ch_commit[i]);

    // R5: period count moves only after a write to this channel's period register
    assert_period_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr && is_base(bus_addr, 32 + 32*i)) |-> $stable(ch_period[16*i +: 16]));

    // R4: duty moves only after a write to this channel's duty register
    assert_duty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr && is_base(bus_addr, 16 + 32*i)) |-> $stable(ch_duty[16*i +: 16]));
  end

endmodule

bind pwm_bank_regs pwm_bank_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ch_enable (ch_enable),
  .ch_duty   (ch_duty),
  .ch_period (ch_period),
  .ch_commit (ch_commit)
);

// File: tb/pwm_bank_regs_tb_top.sv
module pwm_bank_regs_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] ch_enable, ch_commit;
  logic [16*NCH-1:0] ch_duty, ch_period;
  logic [2*NCH-1:0] ch_act_lvl, ch_idle_lvl;
  logic [3*NCH-1:0] ch_presc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_bank_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_enable(ch_enable),
    .ch_duty(ch_duty), .ch_period(ch_period), .ch_act_lvl(ch_act_lvl),
    .ch_idle_lvl(ch_idle_lvl), .ch_presc(ch_presc), .ch_commit(ch_commit)
  );

  // Bench model of the register contents
  logic [31:0] m_en;
  logic [31:0] m_duty [NCH];
  logic [31:0] m_per  [NCH];
  logic [NCH-1:0] m_commit;

  // kind: 0 none, 1 enable, 2 duty, 3 period
  function automatic int region(input logic [AW-1:0] a, output int ch);
    int base;
    base = int'(a) / 16 * 16;
    ch = 0;
    if (base == 0) return 1;
    for (int n = 0; n < NCH; n++) begin
      ch = n;
      if (base == 16 + 32 * n) return 2;
      if (base == 32 + 32 * n) return 3;
    end
    return 0;
  endfunction

  function automatic logic [31:0] alias_result(input logic [AW-1:0] a,
                                               input logic [31:0] cur, input logic [31:0] d);
    case ((int'(a) % 16) / 4)
      0: return d;
      1: return cur | d;
      2: return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int ch;
    case (region(a, ch))
      1: return m_en;
      2: return m_duty[ch];
      3: return m_per[ch];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [31:0] cmp;
    check(ch_enable == m_en[NCH-1:0], req, "enable", 32'(ch_enable), m_en);
    check(ch_commit == m_commit, req, "commit", 32'(ch_commit), 32'(m_commit));
    for (int n = 0; n < NCH; n++) begin
      cmp = {ch_duty[16*n +: 16], 16'h0};
      check(cmp == m_duty[n], req, $sformatf("duty ch%0d", n), cmp, m_duty[n]);
      cmp = {9'h0, ch_presc[3*n +: 3], ch_idle_lvl[2*n +: 2], ch_act_lvl[2*n +: 2],
             ch_period[16*n +: 16]};
      check(cmp == m_per[n], req, $sformatf("period ch%0d", n), cmp, m_per[n]);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    int ch, k;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    k = region(a, ch);
    m_commit = '0;
    case (k)
      1: m_en = alias_result(a, m_en, d) & ((32'd1 << NCH) - 1);
      2: m_duty[ch] = alias_result(a, m_duty[ch], d) & 32'hFFFF_0000;
      3: begin
           m_per[ch] = alias_result(a, m_per[ch], d) & 32'h007F_FFFF;
           m_commit[ch] = 1'b1;
         end
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
    check_outputs(req);
    m_commit = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    e = model_read(a);
    check(bus_rdata == e, req, $sformatf("read @%h", a), bus_rdata, e);
  endtask

  initial begin
    int c;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    m_en = '0; m_commit = '0;
    for (int n = 0; n < NCH; n++) begin m_duty[n] = '0; m_per[n] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8: reset state
    @(negedge clk);
    check_outputs("R8");
    do_read(12'h000, "R8"); do_read(12'h030, "R8"); do_read(12'h080, "R8");

    // R1: reserved enable bits
    do_write(12'h000, 32'hFFFF_FFFF, "R1");
    do_read(12'h000, "R1");
    // R2: set / clear / toggle on enable
    do_write(12'h008, 32'h0000_0005, "R2");
    do_write(12'h004, 32'h0000_0001, "R2");
    do_write(12'h00C, 32'hFFFF_FFFF, "R2");
    do_read(12'h000, "R2");
    // R5 / R6: full period word, commit on channel 2 only
    do_write(12'h060, 32'hFFFF_FFFF, "R5");
    do_read(12'h060, "R5");
    do_write(12'h06B, 32'h0012_3456, "R6");
    // R4 / R9: duty write, no commit
    do_write(12'h010 + 12'h020 * 3, 32'hABCD_1234, "R9");
    do_read(12'h070, "R4");
    // R3: read at every alias offset
    for (int o = 0; o < 16; o += 4) do_read(12'h060 + 12'(o), "R3");
    for (int o = 0; o < 16; o += 4) do_read(12'h070 + 12'(o), "R3");
    // R2: low address bits ignored (0x25 acts as set on period 0)
    do_write(12'h025, 32'h0000_00F0, "R2");
    do_read(12'h020, "R2");
    // R7: slots beyond NUM_CH, and far space
    do_write(12'h090, 32'hFFFF_FFFF, "R7");
    do_write(12'h0A0, 32'hFFFF_FFFF, "R7");
    do_write(12'h7F0, 32'hFFFF_FFFF, "R7");
    do_read(12'h090, "R7"); do_read(12'h0A4, "R7"); do_read(12'hFFC, "R7");
    // R6: back-to-back period writes to different channels
    do_write(12'h020, 32'h0000_0011, "R6");
    do_write(12'h080, 32'h0000_0022, "R6");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      c = int'($urandom % 5);
      case (c)
        0: a = 12'($urandom % 4) | 12'(($urandom % 4) * 4);
        1: a = 12'h010 + 12'(($urandom % 8) * 32) + 12'($urandom % 16);
        2: a = 12'h020 + 12'(($urandom % 8) * 32) + 12'($urandom % 16);
        default: a = 12'($urandom);
      endcase
      if ($urandom % 3 == 0) do_read(a, "R3");
      else do_write(a, $urandom, "R2");
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule